// File: doc/BRIEF.md
# Password-Gated Sector Memory Transaction Controller

This block sits behind a byte-level serial front end and runs every transaction against a small protected memory of fourteen sectors of eight bytes (112 bytes in all). The front end reports bus start and stop events, delivers each received byte on a receive stream and pulls read bytes from a transmit stream. For every received byte the controller answers with an acknowledge or a refusal one cycle later, and the front end puts that answer on the bus.

A transaction opens with a start and a command byte that names an operation and, for data access, a sector. Eight password bytes follow. They are checked against the stored write or read password after a timed busy interval. The host then sends the poll byte 55h. Once the interval has ended and the password matched, access is granted: eight data bytes are collected for a sector write or a password change, or the array is streamed out from the first byte of the sector. A committed write lands in the array or the password store only at the end of a second timed busy interval. Any refusal, abort or completed transaction leaves the controller in standby, waiting for a start.

The receive stream has no back-pressure: `rx_valid_i` is a single-cycle strobe and the byte is taken in that cycle. The transmit stream is valid/ready. `tx_data_o` holds steady while `tx_valid_o` is high and `tx_ready_i` is low, and the read position advances on each cycle where both are high.

Top module: `sector_vault_ctrl`

## Requirements
- R1: The command bytes {100, s[3:0], 0} (sector write), {100, s[3:0], 1} (sector read) for s from 0 to 13, FCh (replace write password) and FEh (replace read password) are acknowledged (`ack_o`=1) when no busy interval is running. The controller then takes password bytes.
- R2: Every other command byte is refused (`ack_o`=0) and the controller returns to standby. This includes sector codes 14 and 15 and 55h outside a poll. In standby, bytes that arrive without a preceding start get no answer at all.
- R3: Each of the 8 password bytes is acknowledged. The write password is used for sector writes and for both password changes; the read password is used for sector reads. After the eighth byte `busy_o` is high for BUSY_CYCLES cycles. A poll byte 55h sent during that interval is refused, and the controller keeps waiting for a later poll.
- R4: A poll sent after the interval is acknowledged and grants access if the entered bytes match the stored password (first byte most significant). Otherwise it is refused and the controller returns to standby. Any byte other than 55h in that state is also refused.
- R5: A sector write that receives exactly 8 data bytes and then a stop stores data byte k at offset k of the addressed sector when its busy interval ends.
- R6: A write stopped after fewer than 8 data bytes, or after more, leaves memory unchanged and starts no busy interval. Data bytes beyond the eighth are refused.
- R7: A committing stop raises `busy_o` for exactly BUSY_CYCLES cycles. A command byte received while `busy_o` is high is refused.
- R8: A granted read starts at the sector's first byte, walks the addresses in order across sector boundaries, and wraps from byte 111 to byte 0.
- R9: A stop during command, password or write-data input abandons the transaction and goes to standby. A start there abandons it and accepts a fresh command byte.
- R10: While read data is being driven, start and stop are ignored. Only `rd_end_i` ends the read and returns to standby.
- R11: A password change writes its 8 data bytes as the new password (first byte most significant) at the end of its busy interval. Later sessions accept only the new password.
- R12: After reset both passwords and every memory byte are zero, and `busy_o`, `ack_valid_o` and `tx_valid_o` are low.
- R13: `ack_valid_o` pulses in the cycle after each byte accepted outside standby, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Bus start event, one-cycle strobe |
| stop_i | input | 1 | Bus stop event, one-cycle strobe |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_data_i | input | 8 | Received byte |
| ack_valid_o | output | 1 | Answer for the previous received byte is present |
| ack_o | output | 1 | 1 = acknowledge, 0 = refuse |
| tx_valid_o | output | 1 | Read byte available |
| tx_data_o | output | 8 | Read byte |
| tx_ready_i | input | 1 | Front end takes the read byte |
| rd_end_i | input | 1 | Host has ended the read (final refusal seen) |
| busy_o | output | 1 | Password check or nonvolatile commit interval running |

## Verification
The bench sweeps all 256 command codes. A decoder that let sector 14 or 15 through, or that let the poll code open a session, would answer those codes with an acknowledge. Writes of five and nine bytes, and a write cut short by a start, test the exact-count rule: a design that counted loosely would corrupt a sector or raise busy. Reads that start at sector 13 and a full pass across all 112 bytes expose a wrong base address or a missing wrap. A poll sent during the password interval, a command sent during a commit, and start and stop strobes injected into a read target the timing and ignore rules. Password replacement is followed by sessions with the old and the new values, which catches a change applied to the wrong store or never applied.

// File: rtl/svc_pkg.sv
package svc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_PWD, ST_POLL, ST_WDATA, ST_RDATA
  } state_t;

  typedef enum logic [1:0] {
    OP_WRITE, OP_READ, OP_SET_WPW, OP_SET_RPW
  } op_t;

  localparam logic [7:0] CMD_SET_WPW = 8'hFC;
  localparam logic [7:0] CMD_SET_RPW = 8'hFE;
  localparam logic [7:0] CMD_POLL    = 8'h55;
  localparam logic [2:0] CMD_SEC_TAG = 3'b100;
  localparam int         SEC_FIELD_W = 4;
endpackage

// File: rtl/svc_cmd_decode.sv
module svc_cmd_decode
  import svc_pkg::*;
#(
  parameter int SECTORS = 14
) (
  input  logic [7:0]             cmd_i,
  output logic                   legal_o,
  output op_t                    op_o,
  output logic [SEC_FIELD_W-1:0] sector_o
);
  always_comb begin
    legal_o  = 1'b0;
    op_o     = OP_WRITE;
    sector_o = cmd_i[4:1];
    if (cmd_i[7:5] == CMD_SEC_TAG) begin
      legal_o = (int'(cmd_i[4:1]) < SECTORS);
      op_o    = cmd_i[0] ? OP_READ : OP_WRITE;
    end else if (cmd_i == CMD_SET_WPW) begin
      legal_o  = 1'b1;
      op_o     = OP_SET_WPW;
      sector_o = '0;
    end else if (cmd_i == CMD_SET_RPW) begin
      legal_o  = 1'b1;
      op_o     = OP_SET_RPW;
      sector_o = '0;
    end
  end

  // R2: sector codes at or beyond SECTORS never decode as legal
  always_comb begin
    if (cmd_i[7:5] == CMD_SEC_TAG && int'(cmd_i[4:1]) >= SECTORS)
      a_bad_sector_r2: assert (!legal_o);
  end
endmodule

// File: rtl/svc_pw_verify.sv
module svc_pw_verify #(
  parameter int PW_BYTES = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_i,
  input  logic                  shift_i,
  input  logic [7:0]            byte_i,
  input  logic                  use_rd_i,
  input  logic                  set_i,
  input  logic                  set_rd_i,
  input  logic [PW_BYTES*8-1:0] set_val_i,
  output logic                  match_o
);
  localparam int PW_W = PW_BYTES * 8;

  logic [PW_W-1:0] rd_pw_q, wr_pw_q, entry_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pw_q <= '0;
      wr_pw_q <= '0;
      entry_q <= '0;
    end else begin
      if (clr_i)        entry_q <= '0;
      else if (shift_i) entry_q <= {entry_q[PW_W-9:0], byte_i};
      if (set_i) begin
        if (set_rd_i) rd_pw_q <= set_val_i;
        else          wr_pw_q <= set_val_i;
      end
    end
  end

  assign match_o = (entry_q == (use_rd_i ? rd_pw_q : wr_pw_q));

  // R11: stored passwords only move on a commit
  p_pw_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !set_i |=> ($stable(rd_pw_q) && $stable(wr_pw_q)));
endmodule

// File: rtl/svc_sector_store.sv
module svc_sector_store #(
  parameter int SECTORS      = 14,
  parameter int SECTOR_BYTES = 8,
  parameter int SEC_W        = 4,
  localparam int DEPTH       = SECTORS * SECTOR_BYTES,
  localparam int AW          = $clog2(DEPTH),
  localparam int LINE_W      = SECTOR_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [SEC_W-1:0]  wsec_i,
  input  logic [LINE_W-1:0] wline_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [7:0]        rdata_o
);
  logic [7:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    localparam int SEC = g / SECTOR_BYTES;
    localparam int OFF = g % SECTOR_BYTES;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem_q[g] <= '0;
      else if (we_i && int'(wsec_i) == SEC)
        mem_q[g] <= wline_i[LINE_W-1-8*OFF -: 8];
    end
  end

  assign rdata_o = mem_q[raddr_i];

  // R5: a commit only ever targets an existing sector
  p_sector_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |-> (int'(wsec_i) < SECTORS));
endmodule

// File: rtl/sector_vault_ctrl.sv
module sector_vault_ctrl
  import svc_pkg::*;
#(
  parameter int SECTORS      = 14,
  parameter int SECTOR_BYTES = 8,
  parameter int BUSY_CYCLES  = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_data_i,
  output logic       ack_valid_o,
  output logic       ack_o,
  output logic       tx_valid_o,
  output logic [7:0] tx_data_o,
  input  logic       tx_ready_i,
  input  logic       rd_end_i,
  output logic       busy_o
);
  localparam int DEPTH  = SECTORS * SECTOR_BYTES;
  localparam int AW     = $clog2(DEPTH);
  localparam int LINE_W = SECTOR_BYTES * 8;
  localparam int CNT_W  = $clog2(SECTOR_BYTES + 2);
  localparam int BW     = $clog2(BUSY_CYCLES + 1);
  localparam logic [AW-1:0]    LAST_ADDR = AW'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(SECTOR_BYTES);

  state_t                 state_q;
  op_t                    op_q, dec_op;
  logic [SEC_FIELD_W-1:0] sec_q, dec_sec;
  logic                   dec_legal;
  logic [CNT_W-1:0]       cnt_q;
  logic [LINE_W-1:0]      line_q;
  logic [AW-1:0]          rd_addr_q;
  logic [BW-1:0]          busy_q;
  logic                   pend_q;
  logic                   ack_v_q, ack_q;
  logic                   pw_match, commit_now, store_we, pw_set;
  logic [7:0]             rd_byte;

  svc_cmd_decode #(.SECTORS(SECTORS)) u_decode (
    .cmd_i(rx_data_i), .legal_o(dec_legal), .op_o(dec_op), .sector_o(dec_sec)
  );

  assign commit_now = pend_q && (busy_q == BW'(1));
  assign store_we   = commit_now && (op_q == OP_WRITE);
  assign pw_set     = commit_now && (op_q == OP_SET_WPW || op_q == OP_SET_RPW);

  svc_pw_verify #(.PW_BYTES(SECTOR_BYTES)) u_pw (
    .clk(clk), .rst_n(rst_n),
    .clr_i(state_q == ST_CMD),
    .shift_i(state_q == ST_PWD && rx_valid_i && !stop_i && !start_i),
    .byte_i(rx_data_i),
    .use_rd_i(op_q == OP_READ),
    .set_i(pw_set),
    .set_rd_i(op_q == OP_SET_RPW),
    .set_val_i(line_q),
    .match_o(pw_match)
  );

  svc_sector_store #(.SECTORS(SECTORS), .SECTOR_BYTES(SECTOR_BYTES), .SEC_W(SEC_FIELD_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we_i(store_we), .wsec_i(sec_q),
    .wline_i(line_q), .raddr_i(rd_addr_q), .rdata_o(rd_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      op_q      <= OP_WRITE;
      sec_q     <= '0;
      cnt_q     <= '0;
      line_q    <= '0;
      rd_addr_q <= '0;
      busy_q    <= '0;
      pend_q    <= 1'b0;
      ack_v_q   <= 1'b0;
      ack_q     <= 1'b0;
    end else begin
      ack_v_q <= 1'b0;
      ack_q   <= 1'b0;
      if (busy_q != '0) busy_q <= busy_q - BW'(1);
      if (commit_now) pend_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) state_q <= ST_CMD;
        ST_CMD: begin
          if (stop_i) state_q <= ST_IDLE;
          else if (rx_valid_i) begin
            ack_v_q <= 1'b1;
            if (busy_q == '0 && dec_legal) begin
              ack_q   <= 1'b1;
              op_q    <= dec_op;
              sec_q   <= dec_sec;
              cnt_q   <= '0;
              state_q <= ST_PWD;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_PWD: begin
          if (stop_i) state_q <= ST_IDLE;
          else if (start_i) state_q <= ST_CMD;
          else if (rx_valid_i) begin
            ack_v_q <= 1'b1;
            ack_q   <= 1'b1;
            cnt_q   <= cnt_q + CNT_W'(1);
            if (cnt_q == FULL_CNT - CNT_W'(1)) begin
              state_q <= ST_POLL;
              busy_q  <= BW'(BUSY_CYCLES);
              cnt_q   <= '0;
            end
          end
        end
        ST_POLL: begin
          if (stop_i) state_q <= ST_IDLE;
          else if (rx_valid_i) begin
            ack_v_q <= 1'b1;
            if (rx_data_i == CMD_POLL && busy_q != '0) begin
              state_q <= ST_POLL;
            end else if (rx_data_i == CMD_POLL && pw_match) begin
              ack_q <= 1'b1;
              cnt_q <= '0;
              if (op_q == OP_READ) begin
                state_q   <= ST_RDATA;
                rd_addr_q <= AW'(int'(sec_q) * SECTOR_BYTES);
              end else begin
                state_q <= ST_WDATA;
              end
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_WDATA: begin
          if (stop_i) begin
            state_q <= ST_IDLE;
            if (cnt_q == FULL_CNT) begin
              busy_q <= BW'(BUSY_CYCLES);
              pend_q <= 1'b1;
            end
          end else if (start_i) begin
            state_q <= ST_CMD;
          end else if (rx_valid_i) begin
            ack_v_q <= 1'b1;
            if (cnt_q < FULL_CNT) begin
              ack_q  <= 1'b1;
              line_q <= {line_q[LINE_W-9:0], rx_data_i};
            end
            if (cnt_q <= FULL_CNT) cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_RDATA: begin
          if (rd_end_i) state_q <= ST_IDLE;
          else if (tx_ready_i)
            rd_addr_q <= (rd_addr_q == LAST_ADDR) ? '0 : rd_addr_q + AW'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ack_valid_o = ack_v_q;
  assign ack_o       = ack_q;
  assign tx_valid_o  = (state_q == ST_RDATA);
  assign tx_data_o   = rd_byte;
  assign busy_o      = (busy_q != '0);

  // R13: an answer only ever follows a received byte
  p_ack_follows_byte_r13: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid_o |-> $past(rx_valid_i));

  // R7: command bytes during a busy interval are refused
  p_busy_nack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CMD && rx_valid_i && !stop_i && busy_o) |=> (ack_valid_o && !ack_o));

  // R6: data bytes past the eighth are refused
  p_overrun_nack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WDATA && rx_valid_i && !stop_i && !start_i && cnt_q >= FULL_CNT)
      |=> (ack_valid_o && !ack_o));

  // R8: the read address wraps from the last byte to byte 0
  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && tx_ready_i && !rd_end_i && rd_addr_q == LAST_ADDR) |=> (rd_addr_q == '0));

  // R10: only the read-end strobe leaves the read state
  p_read_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_o && !rd_end_i) |=> tx_valid_o);

  // R5: commits land only inside a busy interval
  p_commit_in_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (store_we || pw_set) |-> busy_o);
endmodule

// File: tb/test_sector_vault_ctrl.sv
module test_sector_vault_ctrl;
  localparam int SECTORS = 14;
  localparam int SB      = 8;
  localparam int BUSY    = 6;
  localparam int DEPTH   = SECTORS * SB;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, stop_i = 1'b0, rx_valid_i = 1'b0, tx_ready_i = 1'b0, rd_end_i = 1'b0;
  logic [7:0] rx_data_i = 8'h00;
  logic ack_valid_o, ack_o, tx_valid_o, busy_o;
  logic [7:0] tx_data_o;

  always #4 clk = ~clk;

  sector_vault_ctrl #(.SECTORS(SECTORS), .SECTOR_BYTES(SB), .BUSY_CYCLES(BUSY)) i_sector_vault_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i),
    .ack_valid_o(ack_valid_o), .ack_o(ack_o),
    .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o), .tx_ready_i(tx_ready_i),
    .rd_end_i(rd_end_i), .busy_o(busy_o)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  bit done = 1'b0;
  logic [7:0] model [DEPTH];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d cycles expected below 150000", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
  endtask

  task automatic pulse_stop();
    stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, output bit v, output bit a);
    rx_valid_i = 1'b1; rx_data_i = b;
    @(negedge clk);
    v = ack_valid_o; a = ack_o;
    rx_valid_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_exp(input logic [7:0] b, input bit exp, input string req);
    bit v, a;
    send(b, v, a);
    chk(v && (a == exp), req, {v, a}, {1'b1, exp});
  endtask

  task automatic no_answer(input string req);
    bit v, a;
    send(8'hA5, v, a);
    chk(!v, req, v, 0);
  endtask

  task automatic open_session(input logic [7:0] cmd, input logic [63:0] pw,
                              input bit poll_exp, input string req);
    pulse_start();
    send_exp(cmd, 1'b1, "R1");
    for (int k = 0; k < SB; k++) send_exp(pw[63-8*k -: 8], 1'b1, "R3");
    repeat (BUSY + 1) @(negedge clk);
    chk(!busy_o, "R3", busy_o, 0);
    pulse_start();
    send_exp(8'h55, poll_exp, req);
  endtask

  task automatic wait_busy(output int c);
    c = 0;
    while (busy_o && c < 1000) begin @(negedge clk); c++; end
  endtask

  function automatic logic [7:0] pat(input int s, input int k, input int seed);
    return 8'((s * 37 + k * 11 + seed) & 255);
  endfunction

  task automatic write_sector(input int s, input logic [63:0] pw, input int seed);
    int c;
    open_session({3'b100, 4'(s), 1'b0}, pw, 1'b1, "R4");
    for (int k = 0; k < SB; k++) begin
      send_exp(pat(s, k, seed), 1'b1, "R5");
      model[s*SB+k] = pat(s, k, seed);
    end
    pulse_stop();
    wait_busy(c);
  endtask

  task automatic read_run(input int addr0, input int n, input string req);
    for (int i = 0; i < n; i++) begin
      chk(tx_valid_o && tx_data_o == model[(addr0 + i) % DEPTH], req,
          {tx_valid_o, tx_data_o}, {1'b1, model[(addr0 + i) % DEPTH]});
      tx_ready_i = 1'b1; @(negedge clk); tx_ready_i = 1'b0;
    end
  endtask

  task automatic end_read();
    rd_end_i = 1'b1; @(negedge clk); rd_end_i = 1'b0;
  endtask

  task automatic read_sector(input int s, input logic [63:0] pw, input int n, input string req);
    open_session({3'b100, 4'(s), 1'b1}, pw, 1'b1, "R4");
    read_run(s * SB, n, req);
    end_read();
  endtask

  initial begin
    int c;
    bit v, a, legal;
    logic [63:0] new_wpw, new_rpw;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(!ack_valid_o && !tx_valid_o && !busy_o, "R12", {ack_valid_o, tx_valid_o, busy_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ack_valid_o && !tx_valid_o && !busy_o, "R12", {ack_valid_o, tx_valid_o, busy_o}, 0);
    // R12: zero passwords and zero array
    read_sector(0, 64'h0, SB, "R12");
    read_sector(13, 64'h0, SB, "R12");
    // R13: no answer in standby without a start
    no_answer("R13");

    // R1 / R2: sweep every command code
    for (int cmd = 0; cmd < 256; cmd++) begin
      legal = ((cmd >> 5) == 4 && ((cmd >> 1) & 15) < SECTORS) || cmd == 8'hFC || cmd == 8'hFE;
      pulse_start();
      send(8'(cmd), v, a);
      chk(v && a == legal, legal ? "R1" : "R2", {v, a}, {1'b1, legal});
      if (legal) pulse_stop();  // R9: stop during password input abandons
      no_answer("R2");
    end

    // R5 / R8: fill every sector, then read across and around the array
    for (int s = 0; s < SECTORS; s++) write_sector(s, 64'h0, 5);
    read_sector(0, 64'h0, DEPTH + SB, "R8");
    read_sector(13, 64'h0, 2 * SB, "R8");
    for (int s = 0; s < SECTORS; s++) read_sector(s, 64'h0, 2, "R8");

    // R4: wrong password refused, then standby
    open_session({3'b100, 4'd2, 1'b1}, 64'h1, 1'b0, "R4");
    no_answer("R4");

    // R3: poll during password interval refused, later poll granted
    pulse_start();
    send_exp({3'b100, 4'd1, 1'b1}, 1'b1, "R1");
    for (int k = 0; k < SB; k++) send_exp(8'h00, 1'b1, "R3");
    chk(busy_o, "R3", busy_o, 1);
    pulse_start();
    send_exp(8'h55, 1'b0, "R3");
    repeat (BUSY + 1) @(negedge clk);
    pulse_start();
    send_exp(8'h55, 1'b1, "R3");
    read_run(SB, SB, "R3");
    end_read();

    // R6: short write
    open_session({3'b100, 4'd3, 1'b0}, 64'h0, 1'b1, "R4");
    for (int k = 0; k < 5; k++) send_exp(8'hEE, 1'b1, "R6");
    pulse_stop();
    chk(!busy_o, "R6", busy_o, 0);
    // R6: long write, ninth byte refused
    open_session({3'b100, 4'd3, 1'b0}, 64'h0, 1'b1, "R4");
    for (int k = 0; k < SB; k++) send_exp(8'hDD, 1'b1, "R6");
    send_exp(8'hDD, 1'b0, "R6");
    pulse_stop();
    chk(!busy_o, "R6", busy_o, 0);
    read_sector(3, 64'h0, SB, "R6");

    // R9: start during write data abandons it and takes a new command
    open_session({3'b100, 4'd3, 1'b0}, 64'h0, 1'b1, "R4");
    for (int k = 0; k < 4; k++) send_exp(8'hCC, 1'b1, "R9");
    pulse_start();
    send_exp({3'b100, 4'd3, 1'b1}, 1'b1, "R9");
    pulse_stop();
    no_answer("R9");
    read_sector(3, 64'h0, SB, "R9");

    // R7: exact busy length after a commit
    open_session({3'b100, 4'd6, 1'b0}, 64'h0, 1'b1, "R4");
    for (int k = 0; k < SB; k++) begin
      send_exp(pat(6, k, 90), 1'b1, "R5");
      model[6*SB+k] = pat(6, k, 90);
    end
    pulse_stop();
    wait_busy(c);
    chk(c == BUSY, "R7", c, BUSY);
    // R7: command during commit refused
    open_session({3'b100, 4'd4, 1'b0}, 64'h0, 1'b1, "R4");
    for (int k = 0; k < SB; k++) begin
      send_exp(pat(4, k, 61), 1'b1, "R5");
      model[4*SB+k] = pat(4, k, 61);
    end
    pulse_stop();
    pulse_start();
    send_exp({3'b100, 4'd4, 1'b1}, 1'b0, "R7");
    wait_busy(c);
    read_sector(4, 64'h0, 2 * SB, "R5");

    // R10: start and stop ignored during read
    open_session({3'b100, 4'd12, 1'b1}, 64'h0, 1'b1, "R4");
    read_run(12 * SB, 3, "R10");
    pulse_start();
    pulse_stop();
    chk(tx_valid_o, "R10", tx_valid_o, 1);
    read_run(12 * SB + 3, 6, "R10");
    end_read();
    chk(!tx_valid_o, "R10", tx_valid_o, 0);
    no_answer("R10");

    // R11: replace the write password
    new_wpw = 64'hA1B2C3D4E5F60718;
    open_session(8'hFC, 64'h0, 1'b1, "R11");
    for (int k = 0; k < SB; k++) send_exp(new_wpw[63-8*k -: 8], 1'b1, "R11");
    pulse_stop();
    wait_busy(c);
    open_session({3'b100, 4'd5, 1'b0}, 64'h0, 1'b0, "R11");
    write_sector(5, new_wpw, 17);
    // R11: replace the read password, authorised by the write password
    new_rpw = 64'h0F1E2D3C4B5A6978;
    open_session(8'hFE, new_wpw, 1'b1, "R11");
    for (int k = 0; k < SB; k++) send_exp(new_rpw[63-8*k -: 8], 1'b1, "R11");
    pulse_stop();
    wait_busy(c);
    open_session({3'b100, 4'd5, 1'b1}, 64'h0, 1'b0, "R11");
    read_sector(5, new_rpw, SB, "R11");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule